// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block acts as the target side of a two-wire serial memory whose bus lines are not sampled from a real bus. Host software writes line levels into a register, and each write reaches the block as one update: a pulse on `line_wr` carrying the new clock level (`scl_in`) and data level (`sda_in`). The block compares each update with the levels of the previous one. From that it sees START and STOP conditions and clock rising and falling edges, and it steps a single tick counter through a control byte and then a word-address byte, both received MSB first.

Storage is a 256-byte constant table computed inside the block. It cannot be written. A transaction in write mode only collects an address, and at the end of the address byte the byte at that address is loaded into the output shift register. A later transaction in read mode then shifts that byte out MSB first during its own address phase. The same phase collects a new address, which selects the byte for the next read. Every byte is acknowledged on the clock rising edge that follows it.

`sda_out` behaves as an open-drain line. It is 1 (released) unless the block is pulling the line low, so the SDA level the host sees is the AND of its own SDA and `sda_out`. The block releases the line on every update in which it does not actively drive a 0.

Top module: `i2c_ee_target`

## Requirements
- R1: After a synchronous reset, `sda_out` is 1 and the block is idle, with no acknowledge pending. The previous line levels are taken as SCL=1, SDA=1.
- R2: While idle (no START seen since reset or since the last STOP, and no acknowledge pending), any number of clock pulses leaves `sda_out` at 1 and produces no acknowledge.
- R3: A START is an update where SCL is 1 both before and after and SDA changes from 1 to 0. It arms the block. The 8th counted control bit after it schedules an acknowledge, and the next SCL rising update drives `sda_out` to 0.
- R4: Any update that is not an acknowledge edge or a read-data edge releases the line. In particular, the falling update after an acknowledge returns `sda_out` to 1.
- R5: After the control acknowledge, the next 8 counted rising edges collect the word address MSB first. In write mode (control LSB = 0) `sda_out` stays 1 on these edges. The rising edge after the 8th address bit is acknowledged with `sda_out` = 0.
- R6: In read mode (control LSB = 1), on each of the 8 address-phase rising edges `sda_out` presents the MSB of the output shift register (0 pulls low, 1 releases), and the register then shifts left. The register holds the byte at the address collected by the previous transaction.
- R7: A rising SCL update in which SDA also changes is discarded: no bit is counted and the counter does not advance.
- R8: A STOP is an update where SCL stays 1 and SDA changes from 0 to 1. It returns the block to idle from any phase and cancels a pending acknowledge.
- R9: The table holds 0x5A at address 0x00, 0xC3 at 0x01, 0x81 at 0x10, 0x3C at 0x7F, 0xA5 at 0xFF, and 0x00 at every other address. The byte is loaded when the 8th address bit is counted, using the address that includes that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_wr | input | 1 | One-cycle pulse marking a new pair of line levels |
| scl_in | input | 1 | Clock line level written by the host |
| sda_in | input | 1 | Data line level written by the host |
| sda_out | output | 1 | Open-drain data drive: 0 pulls low, 1 released |

## Verification
The assertions assume that the line levels change only in a cycle where `line_wr` is high. They also assume that a master following the protocol changes SDA only while SCL is low, except when it deliberately issues a START or STOP. The bench drives every bit as three separate updates: set the data with SCL low, raise SCL, then lower it. It issues START and STOP only with SCL already high. The only time it breaks the rule is a single deliberate update that raises SCL and moves SDA together, which exercises the discard path.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic steady;
        logic bit_val;
    } line_ev_t;

    function automatic logic [31:0] table_value(input int idx);
        logic [31:0] v;
        case (idx)
            0:       v = 32'h5A;
            1:       v = 32'hC3;
            16:      v = 32'h81;
            127:     v = 32'h3C;
            255:     v = 32'hA5;
            default: v = 32'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ee_line_edge.sv
module ee_line_edge
    import i2c_ee_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line_wr,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic prev_scl;
    logic prev_sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_scl <= 1'b1;
            prev_sda <= 1'b1;
        end else if (line_wr) begin
            prev_scl <= scl_in;
            prev_sda <= sda_in;
        end
    end

    always_comb begin
        ev.start   = line_wr && prev_scl && scl_in && prev_sda && !sda_in;
        ev.stop    = line_wr && prev_scl && scl_in && !prev_sda && sda_in;
        ev.rise    = line_wr && !prev_scl && scl_in;
        ev.fall    = line_wr && prev_scl && !scl_in;
        ev.steady  = (prev_sda == sda_in);
        ev.bit_val = sda_in;
    end

    // R7
    edge_class_chk: assert property (@(posedge clk) disable iff (rst)
        (line_wr && scl_in && !sda_in) |=> (prev_scl && !prev_sda));

endmodule

// File: rtl/ee_rom.sv
module ee_rom
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [31:0] full;
        assign full   = table_value(g);
        assign rom[g] = full[DATA_W-1:0];
    end

    assign data = rom[addr];

endmodule

// File: rtl/ee_sequencer.sv
module ee_sequencer
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_wr,
    input  line_ev_t          ev,
    input  logic [DATA_W-1:0] rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              drive_low
);
    localparam int ADDR_LAST = CTRL_W + 1 + ADDR_W;
    localparam int TICK_W    = $clog2(ADDR_LAST + 1);
    localparam logic [TICK_W-1:0] T_CTRL_END = TICK_W'(CTRL_W + 1);
    localparam logic [TICK_W-1:0] T_ADDR_END = TICK_W'(ADDR_LAST);
    localparam logic [TICK_W-1:0] T_ONE      = TICK_W'(1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [CTRL_W-1:0] cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              ack;
        logic              drv;
    } seq_t;

    seq_t st;
    seq_t nx;

    assign rom_addr  = {st.addr[ADDR_W-2:0], ev.bit_val};
    assign drive_low = st.drv;

    always_comb begin
        nx = st;
        if (line_wr) begin
            nx.drv = 1'b0;
            if (ev.start) begin
                nx.tick = T_ONE;
                nx.cmd  = '0;
            end else if (ev.stop) begin
                nx.tick = '0;
                nx.ack  = 1'b0;
            end else if (st.tick == '0 && !st.ack) begin
                nx.drv = 1'b0;
            end else if (ev.rise) begin
                if (st.ack) begin
                    nx.drv = 1'b1;
                    nx.ack = 1'b0;
                end else if (ev.steady) begin
                    if (st.tick < T_CTRL_END) begin
                        nx.cmd  = {st.cmd[CTRL_W-2:0], ev.bit_val};
                        nx.tick = st.tick + T_ONE;
                        if (nx.tick == T_CTRL_END) nx.ack = 1'b1;
                    end else if (st.tick < T_ADDR_END) begin
                        if (st.cmd[0]) nx.drv = ~st.data[DATA_W-1];
                        nx.addr = rom_addr;
                        nx.data = {st.data[DATA_W-2:0], 1'b0};
                        nx.tick = st.tick + T_ONE;
                        if (st.tick + T_ONE == T_ADDR_END) begin
                            nx.data = rom_data;
                            nx.ack  = 1'b1;
                            nx.tick = '0;
                        end
                    end else begin
                        nx.drv = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nx;
        end
    end

    // R3
    start_arms_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st.tick == T_ONE && st.cmd == '0));

    // R3
    ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && st.ack) |=> (drive_low && !st.ack));

    // R4
    fall_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.fall |=> !drive_low);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (line_wr && !ev.start && st.tick == '0 && !st.ack) |=> (!drive_low && st.tick == '0));

    // R7
    discard_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && !ev.steady && !st.ack) |=> ($stable(st.tick) && $stable(st.cmd) && $stable(st.addr)));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st.tick == '0 && !st.ack && !drive_low));

    // R5
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        st.tick <= T_ADDR_END);

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic line_wr,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);
    line_ev_t          ev;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data;
    logic              drive_low;

    ee_line_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_wr (line_wr),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .ev      (ev)
    );

    ee_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    ee_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_wr   (line_wr),
        .ev        (ev),
        .rom_data  (rom_data),
        .rom_addr  (rom_addr),
        .drive_low (drive_low)
    );

    assign sda_out = ~drive_low;

    // R1
    reset_release_chk: assert property (@(posedge clk)
        rst |=> sda_out);

endmodule

// File: tb/i2c_ee_target_test.sv
`timescale 1ns/1ps
module i2c_ee_target_test;
    logic clk = 1'b0;
    logic rst;
    logic line_wr;
    logic scl;
    logic sda;
    logic sda_out;

    always #2 clk = ~clk;

    i2c_ee_target uut (
        .clk     (clk),
        .rst     (rst),
        .line_wr (line_wr),
        .scl_in  (scl),
        .sda_in  (sda),
        .sda_out (sda_out)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    logic  mon_pend = 1'b0;
    logic  exp_q [$];
    string tag_q [$];
    logic  e_cur;
    string t_cur;

    always @(posedge clk) mon_pend <= line_wr && !rst;

    always @(negedge clk) begin
        if (mon_pend && exp_q.size() > 0) begin
            e_cur = exp_q.pop_front();
            t_cur = tag_q.pop_front();
            checks++;
            if (sda_out !== e_cur) begin
                fails++;
                $display("FAIL %s sda_out actual=%0b expected=%0b", t_cur, sda_out, e_cur);
            end
        end
    end

    task automatic upd(input logic s, input logic d, input logic e, input string t);
        scl     = s;
        sda     = d;
        line_wr = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic e, input string t);
        upd(1'b0, b, 1'b1, t);
        upd(1'b1, b, e, t);
        upd(1'b0, b, 1'b1, "R4");
    endtask

    task automatic send_byte(input logic [7:0] v, input logic [7:0] ex, input string t);
        for (int i = 7; i >= 0; i--) send_bit(v[i], ex[i], t);
    endtask

    task automatic do_start(input string t);
        upd(1'b0, 1'b1, 1'b1, t);
        upd(1'b1, 1'b1, 1'b1, t);
        upd(1'b1, 1'b0, 1'b1, t);
        upd(1'b0, 1'b0, 1'b1, t);
    endtask

    task automatic do_ack(input string t);
        send_bit(1'b1, 1'b0, t);
    endtask

    task automatic drain();
        line_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst = 1'b1; line_wr = 1'b0; scl = 1'b1; sda = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (sda_out !== 1'b1) begin
            fails++;
            $display("FAIL R1 sda_out actual=%0b expected=1", sda_out);
        end
        rst = 1'b0;
        @(negedge clk);

        // R2: clock pulses with no START give no acknowledge
        for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b1, "R2");
        for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b1, "R2");

        // R3 / R5: write-mode transaction collecting address 0x10
        do_start("R3");
        send_byte(8'hA0, 8'hFF, "R3");
        do_ack("R3");
        send_byte(8'h10, 8'hFF, "R5");
        do_ack("R5");

        // R6: read back byte at 0x10 (0x81), collect 0x7F
        do_start("R6");
        send_byte(8'hA1, 8'hFF, "R6");
        do_ack("R6");
        send_byte(8'h7F, 8'h81, "R6");
        do_ack("R6");

        // R9: table contents
        do_start("R9");
        send_byte(8'hA1, 8'hFF, "R9");
        do_ack("R9");
        send_byte(8'hFF, 8'h3C, "R9");
        do_ack("R9");

        do_start("R9");
        send_byte(8'hA1, 8'hFF, "R9");
        do_ack("R9");
        send_byte(8'h05, 8'hA5, "R9");
        do_ack("R9");

        do_start("R9");
        send_byte(8'hA1, 8'hFF, "R9");
        do_ack("R9");
        send_byte(8'h00, 8'h00, "R9");
        do_ack("R9");

        do_start("R9");
        send_byte(8'hA1, 8'hFF, "R9");
        do_ack("R9");
        send_byte(8'h01, 8'h5A, "R9");
        do_ack("R9");

        do_start("R9");
        send_byte(8'hA1, 8'hFF, "R9");
        do_ack("R9");
        send_byte(8'h22, 8'hC3, "R9");
        do_ack("R9");

        // R7: rising edge with SDA change is not counted
        do_start("R7");
        upd(1'b0, 1'b0, 1'b1, "R7");
        upd(1'b1, 1'b1, 1'b1, "R7");
        upd(1'b0, 1'b1, 1'b1, "R7");
        send_byte(8'hA0, 8'hFF, "R7");
        do_ack("R7");

        // R8: STOP in mid address returns to idle
        send_bit(1'b1, 1'b1, "R8");
        send_bit(1'b0, 1'b1, "R8");
        send_bit(1'b1, 1'b1, "R8");
        upd(1'b0, 1'b0, 1'b1, "R8");
        upd(1'b1, 1'b0, 1'b1, "R8");
        upd(1'b1, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b1, "R8");

        drain();
        summary();
    end

endmodule